// File: doc/BRIEF.md
# Scatter/Gather List Element Sequencer

This block carries out a list-form DMA command. It takes a command that gives a list of 8-byte elements held in local store, a starting local-store buffer pointer, the upper 32 bits of the effective address, a tag group and an addressing mode. It then walks the list one element at a time. For each element it fetches the entry through a one-cycle-latency read port, checks it, and hands a single transfer to a data mover over a valid/ready interface. It waits for the mover's completion pulse before it moves on.

Live progress registers always show three values: the local-store address the next element will use, the address of the element being worked on, and the list bytes still to be processed. When an element fails a check, the walk stops and an error code is reported. Transfers from earlier elements stay done, and the progress registers keep pointing at the failing element. An element can also ask for a pause. After its transfer completes, the sequencer sets the command's tag bit in a stall status vector and waits until software clears that bit.

Top module: `dma_list_walker`

## Requirements
- R1: A command whose list address or list byte count is not a multiple of 8 fetches nothing and ends with err_code 1. A command with a list byte count of 0 ends at once with done_pulse and err_code 0.
- R2: Element layout: bit 63 is the pause flag, bits 46:32 are the byte count, bits 31:0 are the low effective address, and other bits are ignored. Each transfer request carries xfr_ea = {command high word, element low word}, xfr_lsa = the current buffer pointer and xfr_size = the element byte count.
- R3: An element byte count that is not 0, 1, 2, 4, 8 or a multiple of 16 ends the command with err_code 2.
- R4: An element byte count above 16384 ends the command with err_code 3. This check takes priority over R3, and R3 takes priority over R5 and R6.
- R5: A nonzero element with a misaligned address ends the command with err_code 4. Counts under 16 need natural alignment of the effective address, and counts of 16 or more need 16-byte alignment. The low 4 bits of the buffer pointer must also equal those of the effective address.
- R6: In 64-bit mode only, an element whose low address plus byte count exceeds 2^32 ends the command with err_code 5. Ending exactly at 2^32 is legal.
- R7: After each element completes, the buffer pointer grows by the element byte count, the list pointer grows by 8 and the remaining list bytes drop by 8.
- R8: On an element error, earlier transfers stand and no further request or fetch is made. The list pointer stays at the failing element, and the remaining bytes still include it.
- R9: After an element with the pause flag completes, the stall status bit for the command's tag is set. No further fetch or transfer is made while that bit stays set.
- R10: A clear strobe clears the stall status bits selected by its mask, and a set bit of another tag has no effect on the pause. Once the command's bit clears, the walk resumes.
- R11: A transfer request, once raised, holds xfr_valid and its fields unchanged until xfr_ready.
- R12: An element with byte count 0 makes no transfer request and no alignment check, and still advances the list.
- R13: Out of reset the block is idle with cmd_ready high and all stall bits clear. Each command ends with exactly one done_pulse or err_pulse, never both, and cmd_ready is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_list_addr | input | LS_AW | Local-store address of the first list element |
| cmd_list_bytes | input | LS_AW | List length in bytes |
| cmd_buf_addr | input | LS_AW | Starting local-store buffer pointer |
| cmd_ea_hi | input | 32 | High word of every effective address |
| cmd_tag | input | TAG_W | Tag group of the command |
| cmd_mode64 | input | 1 | 64-bit addressing, enables the 4 GB crossing check |
| ls_rd_en | output | 1 | Local-store read strobe for a list element |
| ls_rd_addr | output | LS_AW | Local-store address of the element read |
| ls_rd_data | input | 64 | Element data, one cycle after the strobe |
| xfr_valid | output | 1 | Transfer request valid |
| xfr_ready | input | 1 | Data mover accepts the request |
| xfr_ea | output | 64 | Effective address of the transfer |
| xfr_lsa | output | LS_AW | Local-store address of the transfer |
| xfr_size | output | SIZE_W | Byte count of the transfer |
| xfr_done | input | 1 | Completion pulse from the data mover |
| stall_status | output | NUM_TAGS | Per-tag pause status |
| stall_clr_valid | input | 1 | Clear strobe for stall status |
| stall_clr_mask | input | NUM_TAGS | Bits to clear |
| prog_lsa | output | LS_AW | Current buffer pointer |
| prog_list_addr | output | LS_AW | Address of the current list element |
| prog_left | output | LS_AW | List bytes not yet processed |
| busy | output | 1 | A command is in progress |
| done_pulse | output | 1 | Command finished without error |
| err_pulse | output | 1 | Command stopped on an error |
| err_code | output | 3 | Code of the last error, 0 when none |

## Verification
The bound checker watches several properties on every cycle. It checks that a pending request holds its fields until accepted, and that every issued request is nonzero, within the size limit and 16-byte aligned when large. It checks that the remaining count only stays put or drops by 8 while busy, that done and error never coincide, and that a clear strobe leaves the masked stall bits clear. Other behaviour can only be shown by the bench's scenarios. This covers the exact error code chosen for each malformed element, including the priority order, and the composed effective address. It also covers the partial transfer left behind by a mid-list error, the pause that holds off the next element until the right tag bit is cleared, and the progress values after each command.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [2:0] {
    E_NONE  = 3'd0,
    E_LIST  = 3'd1,
    E_SIZE  = 3'd2,
    E_BIG   = 3'd3,
    E_ALIGN = 3'd4,
    E_CROSS = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_PARSE, S_ISSUE, S_WAIT, S_STALL
  } walk_e;

  localparam int ELEM_BYTES = 8;
  localparam int PAUSE_BIT  = 63;
  localparam int CNT_LSB    = 32;
  localparam int LO_W       = 32;
endpackage

// File: rtl/dlw_elem_check.sv
module dlw_elem_check
  import dlw_pkg::*;
#(
  parameter int SIZE_W   = 15,
  parameter int MAX_XFER = 16384
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [31:0]       ea_lo,
  input  logic [3:0]        lsa_lo,
  input  logic              mode64,
  output fault_e            fault
);
  logic        too_big, small_ok, bad_size, misalign, crosses;
  logic [3:0]  nat_mask;
  logic [32:0] end_addr;

  always_comb begin
    too_big  = int'(size) > MAX_XFER;
    small_ok = size inside {SIZE_W'(1), SIZE_W'(2), SIZE_W'(4), SIZE_W'(8)};
    bad_size = !(small_ok || size[3:0] == 4'd0);
    nat_mask = (size < SIZE_W'(16)) ? (size[3:0] - 4'd1) : 4'hF;
    misalign = (size != '0) &&
               (((ea_lo[3:0] & nat_mask) != 4'd0) || (lsa_lo != ea_lo[3:0]));
    end_addr = {1'b0, ea_lo} + 33'(size);
    crosses  = mode64 && (end_addr > 33'h1_0000_0000);
    if (too_big)       fault = E_BIG;
    else if (bad_size) fault = E_SIZE;
    else if (misalign) fault = E_ALIGN;
    else if (crosses)  fault = E_CROSS;
    else               fault = E_NONE;
  end
endmodule

// File: rtl/dlw_progress.sv
module dlw_progress #(
  parameter int LS_AW  = 18,
  parameter int SIZE_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LS_AW-1:0]  ld_lsa,
  input  logic [LS_AW-1:0]  ld_list,
  input  logic [LS_AW-1:0]  ld_left,
  input  logic              step,
  input  logic [SIZE_W-1:0] step_size,
  output logic [LS_AW-1:0]  cur_lsa,
  output logic [LS_AW-1:0]  cur_list,
  output logic [LS_AW-1:0]  left
);
  localparam logic [LS_AW-1:0] STRIDE = LS_AW'(8);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lsa  <= '0;
      cur_list <= '0;
      left     <= '0;
    end else if (load) begin
      cur_lsa  <= ld_lsa;
      cur_list <= ld_list;
      left     <= ld_left;
    end else if (step) begin
      cur_lsa  <= cur_lsa + LS_AW'(step_size);
      cur_list <= cur_list + STRIDE;
      left     <= left - STRIDE;
    end
  end
endmodule

// File: rtl/dlw_stall_flags.sv
module dlw_stall_flags #(
  parameter int NUM_TAGS = 32,
  parameter int TAG_W    = $clog2(NUM_TAGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_stb,
  input  logic [TAG_W-1:0]    set_tag,
  input  logic                clr_stb,
  input  logic [NUM_TAGS-1:0] clr_mask,
  output logic [NUM_TAGS-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      for (int t = 0; t < NUM_TAGS; t++) begin
        if (set_stb && set_tag == TAG_W'(t)) flags[t] <= 1'b1;
        else if (clr_stb && clr_mask[t])     flags[t] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_list_walker.sv
module dma_list_walker
  import dlw_pkg::*;
#(
  parameter int LS_AW    = 18,
  parameter int NUM_TAGS = 32,
  parameter int MAX_XFER = 16384,
  parameter int SIZE_W   = $clog2(MAX_XFER) + 1,
  parameter int TAG_W    = $clog2(NUM_TAGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [LS_AW-1:0]    cmd_list_addr,
  input  logic [LS_AW-1:0]    cmd_list_bytes,
  input  logic [LS_AW-1:0]    cmd_buf_addr,
  input  logic [31:0]         cmd_ea_hi,
  input  logic [TAG_W-1:0]    cmd_tag,
  input  logic                cmd_mode64,
  output logic                ls_rd_en,
  output logic [LS_AW-1:0]    ls_rd_addr,
  input  logic [63:0]         ls_rd_data,
  output logic                xfr_valid,
  input  logic                xfr_ready,
  output logic [63:0]         xfr_ea,
  output logic [LS_AW-1:0]    xfr_lsa,
  output logic [SIZE_W-1:0]   xfr_size,
  input  logic                xfr_done,
  output logic [NUM_TAGS-1:0] stall_status,
  input  logic                stall_clr_valid,
  input  logic [NUM_TAGS-1:0] stall_clr_mask,
  output logic [LS_AW-1:0]    prog_lsa,
  output logic [LS_AW-1:0]    prog_list_addr,
  output logic [LS_AW-1:0]    prog_left,
  output logic                busy,
  output logic                done_pulse,
  output logic                err_pulse,
  output logic [2:0]          err_code
);
  localparam logic [LS_AW-1:0] LAST_LEFT = LS_AW'(ELEM_BYTES);

  walk_e              state;
  fault_e             err_q, e_fault;
  logic [31:0]        ea_hi_q;
  logic [TAG_W-1:0]   tag_q;
  logic               mode_q, hold_pause_q;
  logic [SIZE_W-1:0]  hold_size_q;

  logic [SIZE_W-1:0]  e_size;
  logic               e_pause;
  logic [LO_W-1:0]    e_lo;
  logic               cmd_fire, list_bad, zero_elem, step, step_pause, stall_set;
  logic [SIZE_W-1:0]  step_size;

  assign e_size  = ls_rd_data[CNT_LSB +: SIZE_W];
  assign e_pause = ls_rd_data[PAUSE_BIT];
  assign e_lo    = ls_rd_data[LO_W-1:0];

  assign cmd_ready  = (state == S_IDLE);
  assign busy       = (state != S_IDLE);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign list_bad   = (cmd_list_addr[2:0] != 3'd0) || (cmd_list_bytes[2:0] != 3'd0);
  assign ls_rd_en   = (state == S_FETCH);
  assign ls_rd_addr = prog_list_addr;
  assign xfr_valid  = (state == S_ISSUE);
  assign err_code   = err_q;

  assign zero_elem  = (state == S_PARSE) && (e_fault == E_NONE) && (e_size == '0);
  assign step       = ((state == S_WAIT) && xfr_done) || zero_elem;
  assign step_pause = (state == S_WAIT) ? hold_pause_q : e_pause;
  assign step_size  = (state == S_WAIT) ? hold_size_q : '0;
  assign stall_set  = step && step_pause;

  dlw_elem_check #(.SIZE_W(SIZE_W), .MAX_XFER(MAX_XFER)) u_check (
    .size(e_size), .ea_lo(e_lo), .lsa_lo(prog_lsa[3:0]), .mode64(mode_q), .fault(e_fault)
  );

  dlw_progress #(.LS_AW(LS_AW), .SIZE_W(SIZE_W)) u_prog (
    .clk(clk), .rst(rst), .load(cmd_fire), .ld_lsa(cmd_buf_addr),
    .ld_list(cmd_list_addr), .ld_left(cmd_list_bytes), .step(step),
    .step_size(step_size), .cur_lsa(prog_lsa), .cur_list(prog_list_addr), .left(prog_left)
  );

  dlw_stall_flags #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_stall (
    .clk(clk), .rst(rst), .set_stb(stall_set), .set_tag(tag_q),
    .clr_stb(stall_clr_valid), .clr_mask(stall_clr_mask), .flags(stall_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      err_q        <= E_NONE;
      done_pulse   <= 1'b0;
      err_pulse    <= 1'b0;
      ea_hi_q      <= '0;
      tag_q        <= '0;
      mode_q       <= 1'b0;
      hold_pause_q <= 1'b0;
      hold_size_q  <= '0;
      xfr_ea       <= '0;
      xfr_lsa      <= '0;
      xfr_size     <= '0;
    end else begin
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      case (state)
        S_IDLE: if (cmd_fire) begin
          ea_hi_q <= cmd_ea_hi;
          tag_q   <= cmd_tag;
          mode_q  <= cmd_mode64;
          err_q   <= E_NONE;
          if (list_bad) begin
            err_pulse <= 1'b1;
            err_q     <= E_LIST;
          end else if (cmd_list_bytes == '0) begin
            done_pulse <= 1'b1;
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_PARSE;
        S_PARSE: begin
          if (e_fault != E_NONE) begin
            err_pulse <= 1'b1;
            err_q     <= e_fault;
            state     <= S_IDLE;
          end else if (e_size == '0) begin
            if (e_pause) state <= S_STALL;
            else if (prog_left == LAST_LEFT) begin
              done_pulse <= 1'b1;
              state      <= S_IDLE;
            end else state <= S_FETCH;
          end else begin
            hold_pause_q <= e_pause;
            hold_size_q  <= e_size;
            xfr_ea       <= {ea_hi_q, e_lo};
            xfr_lsa      <= prog_lsa;
            xfr_size     <= e_size;
            state        <= S_ISSUE;
          end
        end
        S_ISSUE: if (xfr_ready) state <= S_WAIT;
        S_WAIT: if (xfr_done) begin
          if (hold_pause_q) state <= S_STALL;
          else if (prog_left == LAST_LEFT) begin
            done_pulse <= 1'b1;
            state      <= S_IDLE;
          end else state <= S_FETCH;
        end
        S_STALL: if (!stall_status[tag_q]) begin
          if (prog_left == '0) begin
            done_pulse <= 1'b1;
            state      <= S_IDLE;
          end else state <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlw_checker.sv
module dlw_checker #(
  parameter int LS_AW    = 18,
  parameter int NUM_TAGS = 32,
  parameter int MAX_XFER = 16384,
  parameter int SIZE_W   = 15
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_ready,
  input logic                ls_rd_en,
  input logic                xfr_valid,
  input logic                xfr_ready,
  input logic [63:0]         xfr_ea,
  input logic [LS_AW-1:0]    xfr_lsa,
  input logic [SIZE_W-1:0]   xfr_size,
  input logic [NUM_TAGS-1:0] stall_status,
  input logic                stall_clr_valid,
  input logic [NUM_TAGS-1:0] stall_clr_mask,
  input logic                stall_set,
  input logic [LS_AW-1:0]    prog_left,
  input logic                busy,
  input logic                done_pulse,
  input logic                err_pulse
);
  localparam logic [LS_AW-1:0] STRIDE = LS_AW'(8);

  a_r11_hold_request: assert property (@(posedge clk) disable iff (rst)
    xfr_valid && !xfr_ready |=> xfr_valid && $stable(xfr_ea) && $stable(xfr_lsa) && $stable(xfr_size));

  a_r4_size_limit: assert property (@(posedge clk) disable iff (rst)
    xfr_valid |-> (int'(xfr_size) <= MAX_XFER) && (xfr_size != '0));

  a_r5_big_aligned: assert property (@(posedge clk) disable iff (rst)
    xfr_valid && (xfr_size >= SIZE_W'(16)) |-> (xfr_ea[3:0] == 4'd0) && (xfr_lsa[3:0] == 4'd0));

  a_r7_left_step: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> (prog_left == $past(prog_left)) || (prog_left == $past(prog_left) - STRIDE));

  a_r13_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(done_pulse && err_pulse));

  a_r13_ready_idle: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !xfr_valid && !ls_rd_en);

  a_r8_halt_on_error: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !busy && !xfr_valid);

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    stall_clr_valid && !stall_set |=> (stall_status & $past(stall_clr_mask)) == '0);
endmodule

bind dma_list_walker dlw_checker #(
  .LS_AW(LS_AW), .NUM_TAGS(NUM_TAGS), .MAX_XFER(MAX_XFER), .SIZE_W(SIZE_W)
) i_dlw_checker (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .ls_rd_en(ls_rd_en),
  .xfr_valid(xfr_valid), .xfr_ready(xfr_ready), .xfr_ea(xfr_ea), .xfr_lsa(xfr_lsa),
  .xfr_size(xfr_size), .stall_status(stall_status), .stall_clr_valid(stall_clr_valid),
  .stall_clr_mask(stall_clr_mask), .stall_set(stall_set), .prog_left(prog_left),
  .busy(busy), .done_pulse(done_pulse), .err_pulse(err_pulse)
);

// File: tb/test_dma_list_walker.sv
module test_dma_list_walker;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LS_AW = 18;
  localparam int NT    = 32;
  localparam int SW    = 15;
  localparam int TW    = 5;
  localparam int NV    = 18;

  // {size[14:0], ea_lo[31:0], buf[17:0], mode64, expected code[2:0]}
  localparam logic [68:0] VEC [0:NV-1] = '{
    {15'd16,    32'h0000_1000, 18'h00200, 1'b0, 3'd0},
    {15'd8,     32'h0000_1008, 18'h00208, 1'b0, 3'd0},
    {15'd4,     32'h0000_1004, 18'h00204, 1'b0, 3'd0},
    {15'd1,     32'h0000_1003, 18'h00203, 1'b0, 3'd0},
    {15'd2,     32'h0000_1003, 18'h00203, 1'b0, 3'd4},
    {15'd24,    32'h0000_1000, 18'h00200, 1'b0, 3'd2},
    {15'd16384, 32'h0000_2000, 18'h00000, 1'b0, 3'd0},
    {15'd16400, 32'h0000_2000, 18'h00000, 1'b0, 3'd3},
    {15'd4097,  32'h0000_2000, 18'h00000, 1'b0, 3'd2},
    {15'd16,    32'h0000_1008, 18'h00208, 1'b0, 3'd4},
    {15'd16,    32'h0000_1000, 18'h00208, 1'b0, 3'd4},
    {15'd32,    32'hFFFF_FFF0, 18'h00000, 1'b1, 3'd5},
    {15'd32,    32'hFFFF_FFF0, 18'h00000, 1'b0, 3'd0},
    {15'd16,    32'hFFFF_FFF0, 18'h00000, 1'b1, 3'd0},
    {15'd0,     32'h0000_1234, 18'h00005, 1'b0, 3'd0},
    {15'd16400, 32'h0000_1001, 18'h00001, 1'b0, 3'd3},
    {15'd24,    32'h0000_1001, 18'h00001, 1'b0, 3'd2},
    {15'd12,    32'h0000_1000, 18'h00000, 1'b1, 3'd2}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [LS_AW-1:0] cmd_list_addr = '0, cmd_list_bytes = '0, cmd_buf_addr = '0;
  logic [31:0]      cmd_ea_hi = '0;
  logic [TW-1:0]    cmd_tag = '0;
  logic             cmd_mode64 = 1'b0;
  logic             ls_rd_en;
  logic [LS_AW-1:0] ls_rd_addr;
  logic [63:0]      ls_rd_data;
  logic             xfr_valid, xfr_ready, xfr_done;
  logic [63:0]      xfr_ea;
  logic [LS_AW-1:0] xfr_lsa;
  logic [SW-1:0]    xfr_size;
  logic [NT-1:0]    stall_status;
  logic             stall_clr_valid = 1'b0;
  logic [NT-1:0]    stall_clr_mask = '0;
  logic [LS_AW-1:0] prog_lsa, prog_list_addr, prog_left;
  logic             busy, done_pulse, err_pulse;
  logic [2:0]       err_code;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  dma_list_walker i_dma_list_walker (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_list_addr(cmd_list_addr), .cmd_list_bytes(cmd_list_bytes),
    .cmd_buf_addr(cmd_buf_addr), .cmd_ea_hi(cmd_ea_hi), .cmd_tag(cmd_tag),
    .cmd_mode64(cmd_mode64), .ls_rd_en(ls_rd_en), .ls_rd_addr(ls_rd_addr),
    .ls_rd_data(ls_rd_data), .xfr_valid(xfr_valid), .xfr_ready(xfr_ready),
    .xfr_ea(xfr_ea), .xfr_lsa(xfr_lsa), .xfr_size(xfr_size), .xfr_done(xfr_done),
    .stall_status(stall_status), .stall_clr_valid(stall_clr_valid),
    .stall_clr_mask(stall_clr_mask), .prog_lsa(prog_lsa),
    .prog_list_addr(prog_list_addr), .prog_left(prog_left), .busy(busy),
    .done_pulse(done_pulse), .err_pulse(err_pulse), .err_code(err_code)
  );

  // local-store model with one cycle of read latency
  logic [63:0] mem [0:255];
  always @(posedge clk) if (ls_rd_en) ls_rd_data <= mem[ls_rd_addr[10:3]];

  // data-mover stub: ready one cycle late, completion two cycles after accept
  logic [7:0]       n_xfr;
  logic [1:0]       pend;
  logic [63:0]      rec_ea   [0:63];
  logic [LS_AW-1:0] rec_lsa  [0:63];
  logic [SW-1:0]    rec_size [0:63];
  always @(posedge clk) begin
    if (rst) begin
      xfr_ready <= 1'b0; xfr_done <= 1'b0; pend <= 2'd0; n_xfr <= 8'd0;
    end else begin
      xfr_ready <= xfr_valid && !xfr_ready;
      xfr_done  <= (pend == 2'd1);
      if (xfr_valid && xfr_ready) begin
        pend <= 2'd2;
        rec_ea[n_xfr[5:0]]   <= xfr_ea;
        rec_lsa[n_xfr[5:0]]  <= xfr_lsa;
        rec_size[n_xfr[5:0]] <= xfr_size;
        n_xfr <= n_xfr + 8'd1;
      end else if (pend != 2'd0) pend <= pend - 2'd1;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit pause, input logic [14:0] sz, input logic [31:0] lo);
    return {pause, 16'd0, sz, lo};
  endfunction

  task automatic put(input int addr, input logic [63:0] e);
    mem[(addr >> 3) & 255] = e;
  endtask

  task automatic start_cmd(input int la, input int lb, input int ba, input logic [31:0] hi,
                           input int tag, input bit m64);
    cmd_list_addr  = LS_AW'(la);
    cmd_list_bytes = LS_AW'(lb);
    cmd_buf_addr   = LS_AW'(ba);
    cmd_ea_hi      = hi;
    cmd_tag        = TW'(tag);
    cmd_mode64     = m64;
    cmd_valid      = 1'b1;
    @(negedge clk);
    cmd_valid      = 1'b0;
  endtask

  task automatic wait_end(output logic [2:0] code, output bit was_done, output bit got);
    got = 0; was_done = 0; code = '0;
    for (int k = 0; k < 400; k++) begin
      if (done_pulse || err_pulse) begin
        got = 1; was_done = done_pulse; code = err_code;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic clear_stall(input logic [NT-1:0] m);
    stall_clr_mask  = m;
    stall_clr_valid = 1'b1;
    @(negedge clk);
    stall_clr_valid = 1'b0;
    stall_clr_mask  = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R13 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [2:0] code;
    bit dn, got;
    int base;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    chk("R13 ready", cmd_ready, 1);
    chk("R13 idle", busy, 0);
    chk("R13 stall clear", stall_status, 0);
    chk("R13 no request", xfr_valid, 0);

    // single-element vector table
    for (int v = 0; v < NV; v++) begin
      logic [14:0] sz;
      logic [31:0] lo;
      logic [17:0] bf;
      logic        m;
      logic [2:0]  ex;
      string       rq;
      int          nexp;
      {sz, lo, bf, m, ex} = VEC[v];
      case (ex)
        3'd2: rq = "R3";
        3'd3: rq = "R4";
        3'd4: rq = "R5";
        3'd5: rq = "R6";
        default: rq = (sz == 0) ? "R12" : "R2";
      endcase
      put(32'h100, mk(1'b0, sz, lo));
      base = n_xfr;
      start_cmd(32'h100, 8, bf, 32'h0000_0004, 3, m);
      wait_end(code, dn, got);
      chk({rq, " ended"}, got, 1);
      chk({rq, " code"}, code, ex);
      nexp = (ex == 0 && sz != 0) ? 1 : 0;
      chk({rq, " transfers"}, n_xfr - base, nexp);
      if (nexp == 1) begin
        chk("R2 ea", rec_ea[base[5:0]], {32'h0000_0004, lo});
        chk("R2 lsa", rec_lsa[base[5:0]], bf);
        chk("R2 size", rec_size[base[5:0]], sz);
      end
      if (ex == 0) begin
        chk("R7 buffer ptr", prog_lsa, LS_AW'(bf + sz));
        chk("R7 left", prog_left, 0);
      end else begin
        chk("R8 list ptr", prog_list_addr, 18'h100);
        chk("R8 left", prog_left, 8);
      end
      @(negedge clk);
    end

    // R1 list geometry
    base = n_xfr;
    start_cmd(32'h104, 8, 0, 0, 0, 0);
    wait_end(code, dn, got);
    chk("R1 misaligned list code", code, 1);
    start_cmd(32'h100, 12, 0, 0, 0, 0);
    wait_end(code, dn, got);
    chk("R1 odd length code", code, 1);
    chk("R1 no transfers", n_xfr - base, 0);
    @(negedge clk);
    start_cmd(32'h100, 0, 0, 0, 0, 0);
    wait_end(code, dn, got);
    chk("R1 empty list done", dn, 1);
    chk("R1 empty list code", code, 0);
    @(negedge clk);

    // R7 three-element walk
    put(32'h200, mk(1'b0, 15'd16, 32'h4000));
    put(32'h208, mk(1'b0, 15'd32, 32'h4010));
    put(32'h210, mk(1'b0, 15'd8,  32'h4030));
    base = n_xfr;
    start_cmd(32'h200, 24, 32'h1000, 32'h0000_0001, 2, 1);
    wait_end(code, dn, got);
    chk("R7 done", dn, 1);
    chk("R7 count", n_xfr - base, 3);
    chk("R7 lsa 2", rec_lsa[(base + 1) & 63], 18'h01010);
    chk("R7 lsa 3", rec_lsa[(base + 2) & 63], 18'h01030);
    chk("R7 final lsa", prog_lsa, 18'h01038);
    chk("R7 final list", prog_list_addr, 18'h00218);
    chk("R7 final left", prog_left, 0);
    @(negedge clk);

    // R8 error on third element leaves a partial transfer
    put(32'h280, mk(1'b0, 15'd16, 32'h5000));
    put(32'h288, mk(1'b0, 15'd16, 32'h5010));
    put(32'h290, mk(1'b0, 15'd24, 32'h5020));
    base = n_xfr;
    start_cmd(32'h280, 24, 32'h2000, 0, 1, 0);
    wait_end(code, dn, got);
    chk("R8 code", code, 2);
    chk("R8 partial count", n_xfr - base, 2);
    chk("R8 list at fault", prog_list_addr, 18'h00290);
    chk("R8 left incl fault", prog_left, 8);
    chk("R8 buffer ptr", prog_lsa, 18'h02020);
    repeat (10) @(negedge clk);
    chk("R8 nothing after error", n_xfr - base, 2);

    // R9 / R10 pause and resume
    put(32'h300, mk(1'b1, 15'd16, 32'h6000));
    put(32'h308, mk(1'b0, 15'd16, 32'h6010));
    base = n_xfr;
    start_cmd(32'h300, 16, 32'h3000, 0, 5, 0);
    repeat (30) @(negedge clk);
    chk("R9 status bit", stall_status, 32'h0000_0020);
    chk("R9 one transfer", n_xfr - base, 1);
    chk("R9 list ptr", prog_list_addr, 18'h00308);
    chk("R9 still busy", busy, 1);
    clear_stall(32'h0000_0001);
    repeat (10) @(negedge clk);
    chk("R10 other bit ignored", stall_status, 32'h0000_0020);
    chk("R10 still paused", n_xfr - base, 1);
    clear_stall(32'h0000_0020);
    wait_end(code, dn, got);
    chk("R10 resumed done", dn, 1);
    chk("R10 status cleared", stall_status, 0);
    chk("R10 second transfer", n_xfr - base, 2);
    chk("R10 left", prog_left, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule